// File: doc/BRIEF.md
# Saturating Wiper Position Controller with Retained Setting

This block is the digital control section of a 100-position digital potentiometer. It takes three slow asynchronous control lines from a host: an active-low select, a step strobe and a direction level. It resynchronises them to the system clock and keeps a wiper count that moves one position on each falling edge of the step strobe. It drives a one-hot bus that closes exactly one tap switch of the resistor string.

When the host releases the select line, the level of the step strobe at that moment chooses what happens. A high strobe copies the count into a retained register, and that write is modelled as a busy period lasting a set number of clock cycles. A low strobe keeps the live position without writing it. The retained register survives the block reset, which stands for a power cycle. On leaving reset the block reloads the count from it, so the wiper comes back to the last saved position.

Top module: `wiper_ctrl`

## Requirements
- R1: `pos_o` stays in the range 0 to NUM_POS-1 (0 to 99 by default), and `taps_o` has exactly one bit set, the bit whose index equals `pos_o`.
- R2: While the select line `sel_n` is high, transitions of `step` and `dir_up` leave `pos_o` unchanged.
- R3: While selected, each high-to-low transition of `step` changes `pos_o` by exactly one. It goes up when `dir_up` is 1 and down when `dir_up` is 0.
- R4: A step up at NUM_POS-1 and a step down at 0 leave `pos_o` unchanged, so the count never wraps.
- R5: A rising edge of `sel_n` while `step` is high writes the current position into the retained register, and a later reset restores that position.
- R6: A rising edge of `sel_n` while `step` is low writes nothing. The live position is kept, and a later reset restores the previously retained value.
- R7: Within a few cycles after reset is released, `pos_o` equals the retained value, which is NV_INIT if nothing was ever written.
- R8: `store_busy_o` is 0 after reset. After a write is chosen it is 1 for exactly STORE_CYCLES consecutive cycles and then returns to 0.
- R9: While a write is busy, `step` edges and a falling edge of `sel_n` are ignored. Once busy ends, a select line that was already held low does not reselect; a fresh high-to-low transition is needed.
- R10: `dir_up` may change between steps within one selection, and each step follows the level present at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, standing for power-up |
| sel_n | input | 1 | Active-low select, asynchronous |
| step | input | 1 | Step strobe; a falling edge moves the wiper, asynchronous |
| dir_up | input | 1 | Direction: 1 toward the high end, 0 toward the low end |
| pos_o | output | POS_W (7) | Current wiper position |
| taps_o | output | NUM_POS (100) | One-hot tap select |
| store_busy_o | output | 1 | High while a retained write is in progress |

## Verification
The count is swept step by step from the recalled value up into the top stop, and then down across the whole range into the bottom stop. Every step checks both the position and the one-hot tap, which separates normal movement from saturation at each end. A session with a mixed up/down pattern shows that each step follows its own direction. Deselects with the strobe low and with it high, each followed by a reset, separate a discarded change from a retained one. A busy write is hit with steps and an early reselect, and the busy length is counted cycle by cycle.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        ST_RECALL  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_WRITE   = 2'd3
    } wstate_e;

endpackage

// File: rtl/in_sync.sv
module in_sync #(
    parameter int          W         = 3,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o
);

    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] lvl_d, lvl_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            meta_d[b] = async_i[b];
            lvl_d[b]  = meta_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            lvl_q  <= RESET_VAL;
        end else begin
            meta_q <= meta_d;
            lvl_q  <= lvl_d;
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
    parameter int NUM_POS = 100,
    parameter int POS_W   = $clog2(NUM_POS)
) (
    input  logic [POS_W-1:0]   pos_i,
    output logic [NUM_POS-1:0] taps_o
);

    for (genvar k = 0; k < NUM_POS; k++) begin : g_tap
        assign taps_o[k] = (pos_i == POS_W'(k));
    end

endmodule

// File: rtl/nv_store.sv
module nv_store #(
    parameter int POS_W       = 7,
    parameter int STORE_CYCLES = 64,
    parameter int NV_INIT     = 0,
    localparam int CNT_W      = $clog2(STORE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [POS_W-1:0] data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [POS_W-1:0] nv_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [POS_W-1:0] wbuf;
    } wr_s;

    wr_s wr_d, wr_q;
    logic done;

    // retained bank: deliberately outside the reset domain
    logic [POS_W-1:0] nv_q = POS_W'(NV_INIT);

    always_comb begin
        wr_d = wr_q;
        done = wr_q.busy && (wr_q.cnt == '0);
        if (start_i && !wr_q.busy) begin
            wr_d.busy = 1'b1;
            wr_d.cnt  = CNT_W'(STORE_CYCLES - 1);
            wr_d.wbuf = data_i;
        end else if (done) begin
            wr_d.busy = 1'b0;
        end else if (wr_q.busy) begin
            wr_d.cnt = wr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    always_ff @(posedge clk) begin
        if (rst_n && done) nv_q <= wr_q.wbuf;
    end

    assign busy_o = wr_q.busy;
    assign done_o = done;
    assign nv_o   = nv_q;

    // R8: no new write may be launched while one is in flight
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q.busy |-> !start_i);

    // R6: retained value only changes at the end of a write
    p_nv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(nv_q));

    // R8: a launched write raises busy on the next cycle
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> wr_q.busy);

endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
    parameter int  NUM_POS      = 100,
    parameter int  STORE_CYCLES = 64,
    parameter int  NV_INIT      = 0,
    localparam int POS_W        = $clog2(NUM_POS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n,
    input  logic               step,
    input  logic               dir_up,
    output logic [POS_W-1:0]   pos_o,
    output logic [NUM_POS-1:0] taps_o,
    output logic               store_busy_o
);
    import wiper_pkg::*;

    localparam logic [POS_W-1:0] POS_MAX = POS_W'(NUM_POS - 1);

    typedef struct packed {
        wstate_e          state;
        logic [POS_W-1:0] pos;
        logic             sel_prev;
        logic             step_prev;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [2:0]       sync_lvl;
    logic             sel_l, step_l, dir_l;
    logic             sel_fall, sel_rise, step_fall;
    logic             store_go;
    logic             nv_busy, nv_done;
    logic [POS_W-1:0] nv_val;

    in_sync #(.W(3), .RESET_VAL(3'b111)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dir_up, step, sel_n}),
        .lvl_o   (sync_lvl)
    );

    assign sel_l  = sync_lvl[0];
    assign step_l = sync_lvl[1];
    assign dir_l  = sync_lvl[2];

    always_comb begin
        ctl_d     = ctl_q;
        store_go  = 1'b0;
        sel_fall  = ctl_q.sel_prev && !sel_l;
        sel_rise  = !ctl_q.sel_prev && sel_l;
        step_fall = ctl_q.step_prev && !step_l;
        ctl_d.sel_prev  = sel_l;
        ctl_d.step_prev = step_l;
        case (ctl_q.state)
            ST_RECALL: begin
                ctl_d.pos   = nv_val;
                ctl_d.state = ST_STANDBY;
            end
            ST_STANDBY: begin
                if (sel_fall) ctl_d.state = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (sel_rise) begin
                    if (step_l) begin
                        store_go    = 1'b1;
                        ctl_d.state = ST_WRITE;
                    end else begin
                        ctl_d.state = ST_STANDBY;
                    end
                end else if (step_fall) begin
                    if (dir_l && ctl_q.pos != POS_MAX)
                        ctl_d.pos = ctl_q.pos + POS_W'(1);
                    else if (!dir_l && ctl_q.pos != '0)
                        ctl_d.pos = ctl_q.pos - POS_W'(1);
                end
            end
            ST_WRITE: begin
                if (nv_done) ctl_d.state = ST_STANDBY;
            end
            default: ctl_d.state = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= ST_RECALL;
            ctl_q.pos       <= '0;
            ctl_q.sel_prev  <= 1'b1;
            ctl_q.step_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    nv_store #(
        .POS_W        (POS_W),
        .STORE_CYCLES (STORE_CYCLES),
        .NV_INIT      (NV_INIT)
    ) i_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (store_go),
        .data_i  (ctl_q.pos),
        .busy_o  (nv_busy),
        .done_o  (nv_done),
        .nv_o    (nv_val)
    );

    tap_decoder #(.NUM_POS(NUM_POS), .POS_W(POS_W)) i_dec (
        .pos_i  (ctl_q.pos),
        .taps_o (taps_o)
    );

    assign pos_o        = ctl_q.pos;
    assign store_busy_o = nv_busy;

    // R1: position inside the legal range
    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o <= POS_MAX);

    // R1: decoder output is one-hot
    p_taps_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(taps_o) == 1);

    // R2: deselected, the position does not move
    p_deselect_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_STANDBY) |=> $stable(pos_o));

    // R3: at most one position per cycle while selected
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_ACTIVE) |=> (pos_o == $past(pos_o) ||
            pos_o == $past(pos_o) + POS_W'(1) || pos_o == $past(pos_o) - POS_W'(1)));

    // R9: busy write freezes the position
    p_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WRITE) |=> $stable(pos_o));

    // R8: busy only while the controller waits on the write
    p_busy_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_busy_o |-> (ctl_q.state == ST_WRITE));

endmodule

// File: tb/test_wiper_ctrl.sv
`timescale 1ns/1ps
module test_wiper_ctrl;

    localparam int NUM_POS = 100;
    localparam int SC      = 40;
    localparam int NVI     = 37;
    localparam int POS_W   = $clog2(NUM_POS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic step = 1'b1;
    logic dir_up = 1'b1;
    logic [POS_W-1:0]   pos_o;
    logic [NUM_POS-1:0] taps_o;
    logic               store_busy_o;

    int checks = 0;
    int fails  = 0;
    int exp_pos = NVI;
    int exp_nv  = NVI;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wiper_ctrl #(.NUM_POS(NUM_POS), .STORE_CYCLES(SC), .NV_INIT(NVI)) i_wiper_ctrl (
        .clk (clk), .rst_n (rst_n), .sel_n (sel_n), .step (step), .dir_up (dir_up),
        .pos_o (pos_o), .taps_o (taps_o), .store_busy_o (store_busy_o)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_pos(input string req);
        logic [NUM_POS-1:0] exp_taps;
        exp_taps = '0;
        exp_taps[exp_pos] = 1'b1;
        chk(int'(pos_o) == exp_pos, req, int'(pos_o), exp_pos);
        chk(taps_o == exp_taps, {req, " R1 tap"}, $clog2(int'(taps_o)), exp_pos);
    endtask

    task automatic pulse(input bit up, input bit model);
        dir_up = up;
        wait_cyc(4);
        step = 1'b0;
        wait_cyc(5);
        step = 1'b1;
        wait_cyc(5);
        if (model) begin
            if (up && exp_pos < NUM_POS - 1) exp_pos++;
            else if (!up && exp_pos > 0) exp_pos--;
        end
    endtask

    task automatic power_cycle();
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(8);
        exp_pos = exp_nv;
    endtask

    task automatic select();
        sel_n = 1'b0;
        wait_cyc(6);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(8);
        // R7: first power-up recalls NV_INIT; R8: not busy
        chk_pos("R7 recall init");
        chk(store_busy_o == 1'b0, "R8 busy after reset", store_busy_o, 0);

        // R2: steps ignored while deselected
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        chk_pos("R2 deselected steps");

        // R3/R4: sweep up into the top stop
        select();
        for (int i = 0; i < 70; i++) begin
            pulse(1'b1, 1'b1);
            chk_pos(exp_pos == NUM_POS - 1 ? "R4 top saturate" : "R3 step up");
        end
        // R3/R4: sweep down through the whole range into the bottom stop
        for (int i = 0; i < 110; i++) begin
            pulse(1'b0, 1'b1);
            chk_pos(exp_pos == 0 ? "R4 bottom saturate" : "R3 step down");
        end
        // R10: direction changed between steps in the same session
        for (int i = 0; i < 12; i++) begin
            pulse((i % 3) != 2, 1'b1);
            chk_pos("R10 mixed direction");
        end

        // R6: deselect with strobe low -> no write
        dir_up = 1'b1;
        wait_cyc(4);
        step = 1'b0;
        wait_cyc(6);
        exp_pos++;
        sel_n = 1'b1;
        wait_cyc(6);
        step = 1'b1;
        wait_cyc(6);
        chk_pos("R6 live position kept");
        chk(store_busy_o == 1'b0, "R6 no write started", store_busy_o, 0);
        power_cycle();
        chk_pos("R6 R7 recall older value");

        // R5/R8: write with strobe high, measure busy length
        select();
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1);
        sel_n = 1'b1;
        begin
            int n = 0;
            int guard = 0;
            while (store_busy_o == 1'b0 && guard < 20) begin
                wait_cyc(1);
                guard++;
            end
            while (store_busy_o == 1'b1 && n < 4 * SC) begin
                n++;
                wait_cyc(1);
            end
            chk(n == SC, "R8 busy length", n, SC);
        end
        exp_nv = exp_pos;
        wait_cyc(4);
        chk_pos("R5 position after write");

        // R9: activity during a busy write is ignored
        select();
        for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
        sel_n = 1'b1;
        wait_cyc(6);
        chk(store_busy_o == 1'b1, "R9 busy started", store_busy_o, 1);
        sel_n = 1'b0;
        wait_cyc(4);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        chk_pos("R9 steps during busy");
        while (store_busy_o == 1'b1) wait_cyc(1);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        chk_pos("R9 no reselect without fresh edge");
        sel_n = 1'b1;
        wait_cyc(6);
        exp_nv = exp_pos;

        // R5: retained value restored by reset
        exp_pos = 0;
        power_cycle();
        chk_pos("R5 recall stored value");
        chk(store_busy_o == 1'b0, "R8 busy clear after reset", store_busy_o, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule